// File: doc/BRIEF.md
# Stealing-Flag Burst Sequencer

This block drives the pair of stealing flags that goes with each burst of a signalling block. A block is opened by a start request that carries a channel-type code. From then on, every burst strobe moves the sequencer to the next burst. For the current burst it shows the upper flag (`flag_up_o`), the lower flag (`flag_lo_o`), the burst position within the block and a marker for the final burst. The flag pattern and the block length both depend on the channel type. A slow associated or common control block uses 4 bursts. A full-rate fast associated block uses 8 bursts. A half-rate fast associated block uses 6 bursts and has a middle phase in which both flags are set.

When no block is open the sequencer is idle and drives every flag low. A start request is taken only in the idle state. While a block is running, further requests are dropped, so a block always runs to its last burst. Channel codes are 0 (slow/common control), 1 (full-rate fast associated) and 2 (half-rate fast associated). Code 3 is reserved.

Top module: `steal_flag_seq`

## Requirements
- R1: While reset is held and after its release, `busy_o`, `flag_up_o`, `flag_lo_o` and `last_o` are 0 and `burst_idx_o` is 0.
- R2: In the idle state, `start_i` high at a clock edge with `chan_i` equal to 0, 1 or 2 makes `busy_o` 1 and `burst_idx_o` 0 from the next cycle.
- R3: For channel code 0 the block lasts 4 bursts, and both flags are 1 on every burst.
- R4: For channel code 1 the block lasts 8 bursts, with only `flag_up_o` set on bursts 0 to 3 and only `flag_lo_o` set on bursts 4 to 7.
- R5: For channel code 2 the block lasts 6 bursts, with only `flag_up_o` set on bursts 0 and 1, both flags set on bursts 2 and 3, and only `flag_lo_o` set on bursts 4 and 5.
- R6: While busy, each clock edge with `burst_str_i` high raises `burst_idx_o` by one. Without a strobe the index and the flags hold.
- R7: `last_o` is 1 exactly while busy on burst index 3, 7 or 5 for codes 0, 1 or 2 respectively.
- R8: A strobe on the last burst returns the sequencer to idle on the next cycle, with both flags 0 and the index 0.
- R9: `start_i` while busy has no effect on the channel, the index or the flags, and this holds even in the cycle of the final strobe.
- R10: `burst_str_i` while idle has no effect.
- R11: A start with the reserved code 3 is ignored, and the sequencer stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to open a block |
| chan_i | input | 2 | Channel-type code sampled with the start request |
| burst_str_i | input | 1 | One pulse per burst boundary |
| busy_o | output | 1 | A block is in progress |
| flag_up_o | output | 1 | Upper stealing flag for the current burst |
| flag_lo_o | output | 1 | Lower stealing flag for the current burst |
| burst_idx_o | output | IDX_W | Burst position within the block |
| last_o | output | 1 | Current burst is the final one of the block |

## Verification
The assertions treat the inputs as synchronous and free of unknown values after reset. They assume nothing about how starts and strobes overlap, so the hold checks are conditioned only on the absence of a strobe. The stimulus changes inputs only at falling edges and deliberately sends starts during a running block, starts on the final-strobe cycle, strobes while idle and the reserved code. This keeps every observed behaviour inside what the properties describe while still reaching each corner they constrain.

// File: rtl/steal_pkg.sv
package steal_pkg;

  typedef enum logic [1:0] {
    CH_CTRL = 2'd0,
    CH_FULL = 2'd1,
    CH_HALF = 2'd2,
    CH_RSVD = 2'd3
  } chan_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_st_t;

  typedef struct packed {
    logic up;
    logic lo;
  } flag_pair_t;

endpackage

// File: rtl/steal_len.sv
module steal_len
  import steal_pkg::*;
#(
  parameter int CTRL_BURSTS = 4,
  parameter int FULL_BURSTS = 8,
  parameter int HALF_BURSTS = 6,
  parameter int IDX_W       = 3
) (
  input  chan_t            chan_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] final_idx_o
);

  localparam logic [IDX_W-1:0] CTRL_FIN = IDX_W'(CTRL_BURSTS - 1);
  localparam logic [IDX_W-1:0] FULL_FIN = IDX_W'(FULL_BURSTS - 1);
  localparam logic [IDX_W-1:0] HALF_FIN = IDX_W'(HALF_BURSTS - 1);

  always_comb begin
    valid_o     = 1'b1;
    final_idx_o = CTRL_FIN;
    unique case (chan_i)
      CH_CTRL: final_idx_o = CTRL_FIN;
      CH_FULL: final_idx_o = FULL_FIN;
      CH_HALF: final_idx_o = HALF_FIN;
      default: begin
        valid_o     = 1'b0;
        final_idx_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/steal_fsm.sv
module steal_fsm
  import steal_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  chan_t            chan_i,
  input  logic             chan_ok_i,
  input  logic             burst_str_i,
  input  logic [IDX_W-1:0] final_idx_i,
  output logic             busy_o,
  output chan_t            chan_q_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);

  seq_st_t          st_q, st_d;
  chan_t            chan_q, chan_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             chan_en, idx_en;
  logic             accept, at_final;

  assign at_final = (st_q == ST_RUN) && (idx_q == final_idx_i);
  assign accept   = (st_q == ST_IDLE) && start_i && chan_ok_i;

  always_comb begin
    st_d    = st_q;
    chan_d  = chan_q;
    idx_d   = idx_q;
    chan_en = 1'b0;
    idx_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d    = ST_RUN;
          chan_d  = chan_i;
          chan_en = 1'b1;
          idx_d   = '0;
          idx_en  = 1'b1;
        end
      end
      ST_RUN: begin
        if (burst_str_i) begin
          idx_en = 1'b1;
          if (at_final) begin
            st_d  = ST_IDLE;
            idx_d = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= CH_CTRL;
    end else if (chan_en) begin
      chan_q <= chan_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign busy_o   = (st_q == ST_RUN);
  assign chan_q_o = chan_q;
  assign idx_o    = idx_q;
  assign last_o   = at_final;

endmodule

// File: rtl/steal_flags.sv
module steal_flags
  import steal_pkg::*;
#(
  parameter int FULL_BURSTS = 8,
  parameter int HALF_BURSTS = 6,
  parameter int IDX_W       = 3
) (
  input  logic             busy_i,
  input  chan_t            chan_i,
  input  logic [IDX_W-1:0] idx_i,
  output flag_pair_t       flags_o
);

  localparam int FULL_SPLIT = FULL_BURSTS / 2;
  localparam int HALF_PHASE = HALF_BURSTS / 3;
  localparam logic [IDX_W-1:0] FULL_B  = IDX_W'(FULL_SPLIT);
  localparam logic [IDX_W-1:0] HALF_B1 = IDX_W'(HALF_PHASE);
  localparam logic [IDX_W-1:0] HALF_B2 = IDX_W'(2 * HALF_PHASE);

  flag_pair_t row_ctrl, row_full, row_half;

  generate
    if ((HALF_BURSTS % 3) != 0 || (FULL_BURSTS % 2) != 0) begin : g_bad_len
      initial $error("steal_flags: block lengths must split evenly into phases");
    end
  endgenerate

  always_comb begin
    row_ctrl = '{up: 1'b1, lo: 1'b1};
    row_full = (idx_i < FULL_B) ? '{up: 1'b1, lo: 1'b0} : '{up: 1'b0, lo: 1'b1};
    if (idx_i < HALF_B1) begin
      row_half = '{up: 1'b1, lo: 1'b0};
    end else if (idx_i < HALF_B2) begin
      row_half = '{up: 1'b1, lo: 1'b1};
    end else begin
      row_half = '{up: 1'b0, lo: 1'b1};
    end
  end

  always_comb begin
    flags_o = '{up: 1'b0, lo: 1'b0};
    if (busy_i) begin
      unique case (chan_i)
        CH_CTRL: flags_o = row_ctrl;
        CH_FULL: flags_o = row_full;
        CH_HALF: flags_o = row_half;
        default: flags_o = '{up: 1'b0, lo: 1'b0};
      endcase
    end
  end

endmodule

// File: rtl/steal_flag_seq.sv
module steal_flag_seq
  import steal_pkg::*;
#(
  parameter int CTRL_BURSTS = 4,
  parameter int FULL_BURSTS = 8,
  parameter int HALF_BURSTS = 6,
  parameter int MAX_BURSTS  = FULL_BURSTS,
  parameter int IDX_W       = $clog2(MAX_BURSTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       chan_i,
  input  logic             burst_str_i,
  output logic             busy_o,
  output logic             flag_up_o,
  output logic             flag_lo_o,
  output logic [IDX_W-1:0] burst_idx_o,
  output logic             last_o
);

  chan_t            chan_in, chan_run, len_sel;
  logic             in_ok, run_ok_unused;
  logic [IDX_W-1:0] in_fin_unused, run_fin;
  logic             busy;
  logic [IDX_W-1:0] idx;
  flag_pair_t       flags;

  assign chan_in = chan_t'(chan_i);
  assign len_sel = chan_run;

  steal_len #(
    .CTRL_BURSTS(CTRL_BURSTS), .FULL_BURSTS(FULL_BURSTS),
    .HALF_BURSTS(HALF_BURSTS), .IDX_W(IDX_W)
  ) u_len_in (
    .chan_i(chan_in), .valid_o(in_ok), .final_idx_o(in_fin_unused)
  );

  steal_len #(
    .CTRL_BURSTS(CTRL_BURSTS), .FULL_BURSTS(FULL_BURSTS),
    .HALF_BURSTS(HALF_BURSTS), .IDX_W(IDX_W)
  ) u_len_run (
    .chan_i(len_sel), .valid_o(run_ok_unused), .final_idx_o(run_fin)
  );

  steal_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_in),
    .chan_ok_i(in_ok), .burst_str_i(burst_str_i), .final_idx_i(run_fin),
    .busy_o(busy), .chan_q_o(chan_run), .idx_o(idx), .last_o(last_o)
  );

  steal_flags #(
    .FULL_BURSTS(FULL_BURSTS), .HALF_BURSTS(HALF_BURSTS), .IDX_W(IDX_W)
  ) u_flags (
    .busy_i(busy), .chan_i(chan_run), .idx_i(idx), .flags_o(flags)
  );

  assign busy_o      = busy;
  assign burst_idx_o = idx;
  assign flag_up_o   = flags.up;
  assign flag_lo_o   = flags.lo;

endmodule

// File: rtl/steal_flag_seq_chk.sv
module steal_flag_seq_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [1:0]       chan_i,
  input logic             burst_str_i,
  input logic             busy_o,
  input logic             flag_up_o,
  input logic             flag_lo_o,
  input logic [IDX_W-1:0] burst_idx_o,
  input logic             last_o
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!flag_up_o && !flag_lo_o && !last_o && burst_idx_o == '0));

  // R2
  start_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && chan_i != 2'd3) |=> (busy_o && burst_idx_o == '0));

  // R6
  step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && burst_str_i && !last_o) |=> (busy_o && burst_idx_o == $past(burst_idx_o) + 1'b1));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !burst_str_i) |=> (busy_o && $stable(burst_idx_o) && $stable(flag_up_o) && $stable(flag_lo_o)));

  // R8
  close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && burst_str_i && last_o) |=> !busy_o);

  // R11
  rsvd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && chan_i == 2'd3) |=> !busy_o);

  // R10
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> !busy_o);

  // R3
  some_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (flag_up_o || flag_lo_o));

endmodule

bind steal_flag_seq steal_flag_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
  .burst_str_i(burst_str_i), .busy_o(busy_o), .flag_up_o(flag_up_o),
  .flag_lo_o(flag_lo_o), .burst_idx_o(burst_idx_o), .last_o(last_o)
);

// File: tb/sim_steal_flag_seq.sv
module sim_steal_flag_seq;

  localparam int IDX_W = 3;

  typedef struct {
    logic       busy;
    logic       up;
    logic       lo;
    logic [2:0] idx;
    logic       last;
    string      req;
  } exp_t;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [1:0]       chan_i;
  logic             burst_str_i;
  logic             busy_o, flag_up_o, flag_lo_o, last_o;
  logic [IDX_W-1:0] burst_idx_o;

  int   n_checks = 0;
  int   n_errors = 0;
  exp_t sb[$];
  bit   done = 0;

  logic       m_busy = 0;
  logic [1:0] m_chan = 0;
  int         m_idx  = 0;

  steal_flag_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
    .burst_str_i(burst_str_i), .busy_o(busy_o), .flag_up_o(flag_up_o),
    .flag_lo_o(flag_lo_o), .burst_idx_o(burst_idx_o), .last_o(last_o)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic int blen(input logic [1:0] c);
    case (c)
      2'd0: return 4;
      2'd1: return 8;
      default: return 6;
    endcase
  endfunction

  function automatic exp_t expect_now(input string req);
    exp_t e;
    e.req  = req;
    e.busy = m_busy;
    e.idx  = m_busy ? 3'(m_idx) : 3'd0;
    e.last = m_busy && (m_idx == blen(m_chan) - 1);
    e.up   = 0;
    e.lo   = 0;
    if (m_busy) begin
      case (m_chan)
        2'd0: begin e.up = 1; e.lo = 1; end
        2'd1: begin e.up = (m_idx < 4); e.lo = (m_idx >= 4); end
        default: begin e.up = (m_idx < 4); e.lo = (m_idx >= 2); end
      endcase
    end
    return e;
  endfunction

  task automatic step(input bit st, input logic [1:0] ch, input bit stb, input string req);
    @(negedge clk);
    start_i     = st;
    chan_i      = ch;
    burst_str_i = stb;
    if (!m_busy) begin
      if (st && ch != 2'd3) begin
        m_busy = 1; m_chan = ch; m_idx = 0;
      end
    end else if (stb) begin
      if (m_idx == blen(m_chan) - 1) begin
        m_busy = 0; m_idx = 0;
      end else begin
        m_idx++;
      end
    end
    sb.push_back(expect_now(req));
  endtask

  task automatic run_block(input logic [1:0] ch, input string req);
    step(1, ch, 0, req);
    for (int i = 1; i < blen(ch); i++) step(0, ch, 1, req);
    step(0, ch, 1, "R8");
  endtask

  // monitor: compares each queued expectation one time unit after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_checks++;
        if (busy_o !== e.busy || flag_up_o !== e.up || flag_lo_o !== e.lo ||
            burst_idx_o !== e.idx || last_o !== e.last) begin
          n_errors++;
          $display("FAIL %s: got busy=%b up=%b lo=%b idx=%0d last=%b, expected busy=%b up=%b lo=%b idx=%0d last=%b",
                   e.req, busy_o, flag_up_o, flag_lo_o, burst_idx_o, last_o,
                   e.busy, e.up, e.lo, e.idx, e.last);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_i = 0; chan_i = 0; burst_str_i = 0;
    // R1: reset state while held
    @(negedge clk);
    sb.push_back(expect_now("R1"));
    @(negedge clk);
    rst_n = 1;
    step(0, 0, 0, "R1");

    // R3 and R2, R7: control-type block
    run_block(2'd0, "R3");
    // R4: full-rate block
    run_block(2'd1, "R4");
    // R5: half-rate block
    run_block(2'd2, "R5");

    // R10: strobes while idle
    step(0, 0, 1, "R10");
    step(0, 2, 1, "R10");

    // R11: reserved code
    step(1, 3, 0, "R11");
    step(1, 3, 1, "R11");

    // R6, R9: full-rate with holds and intruding starts
    step(1, 1, 0, "R2");
    step(0, 1, 0, "R6");
    step(1, 2, 1, "R9");
    step(1, 0, 0, "R9");
    for (int i = 0; i < 3; i++) step(0, 1, 1, "R6");
    step(0, 1, 0, "R6");
    for (int i = 0; i < 3; i++) step(0, 1, 1, "R7");
    step(0, 1, 0, "R7");
    // R9: start arrives with the final strobe
    step(1, 0, 1, "R9");
    step(0, 0, 0, "R8");

    // R5 with pauses, then back to back control block
    step(1, 2, 0, "R5");
    for (int i = 0; i < 5; i++) begin
      step(0, 2, 0, "R6");
      step(0, 2, 1, "R5");
    end
    step(0, 2, 1, "R8");
    run_block(2'd0, "R3");

    step(0, 0, 0, "R1");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule